// File: doc/BRIEF.md
# Lockstep Multi-ADC Channel Sequencer

The block runs a bank of serial ADCs that share one chip-select, one serial clock and one command line. Each ADC returns its result on its own data line. Every ADC has a 64-way input multiplexer. The sequencer steps all converters through the same multiplexer channel at the same time, and it shifts every return line into its own register on the same clock edge. The collected results leave as a stream of 16-bit words, each tagged with a global channel number, under a valid/ready handshake.

A frame timer divides the system clock and starts one frame per period. A frame holds 65 transfers. The command sent in a transfer selects the channel for the next conversion, so the first transfer of a frame only primes the multiplexers and its data is dropped. The data from transfer t belongs to the channel requested in transfer t-1. An enable mask leaves out unpopulated converters. When the consumer stops taking words, the sequencer holds the serial clock between transfers instead of losing samples. If a frame is still running when the next timer tick arrives, the sequencer raises a sticky overrun flag.

Top module: `mcs_adc_sequencer`

## Requirements
- R1: When `frame_period` = P, the frame timer ticks once every P system clocks. A tick that arrives while no frame is running starts a frame of exactly N_MUX+1 transfers.
- R2: During each transfer `adc_cs_n` is low and `adc_sclk` gives exactly 16 rising edges. `adc_sclk` is low whenever `adc_cs_n` is high. `adc_mosi` changes only while `adc_sclk` is low and is sent MSB first. All `adc_miso` lines are sampled on the same rising edges.
- R3: Transfer t of a frame (t = 0..N_MUX) sends the command word `{2'b00, ch[5:0], 8'h00}`, where ch = t for t < N_MUX and ch = 0 for the final transfer.
- R4: The data captured in transfer t (t >= 1) is output as mux channel t-1. The data from transfer 0 is never output.
- R5: Words leave in channel-major order: every enabled ADC for mux channel 0 in ascending ADC index, then every enabled ADC for mux channel 1, and so on. `out_chan` = {mux channel in bits 9:4, ADC index in bits 3:0}.
- R6: An ADC whose `adc_enable` bit is 0 produces no output words. The mask is sampled when a frame starts, and changes made during a frame do not affect that frame.
- R7: `out_last` is 1 on the final word of a frame and 0 on every other word.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_chan` and `out_last` hold their values. No sample is lost under backpressure.
- R9: No transfer begins (falling `adc_cs_n`) while an output word is still pending.
- R10: Between consecutive transfers `adc_cs_n` stays high for at least `cs_gap` system clocks.
- R11: A timer tick that arrives while a frame is running sets `overrun` and does not start or restart a frame. `overrun` stays 1 until reset.
- R12: During reset `adc_cs_n` = 1, `adc_sclk` = 0, `adc_mosi` = 0, `out_valid` = 0 and `overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_period | input | PERIOD_W | System clocks per frame tick |
| cs_gap | input | GAP_W | Minimum chip-select high time in clocks |
| adc_enable | input | N_ADC | One bit per populated ADC |
| adc_cs_n | output | 1 | Shared chip-select, active low |
| adc_sclk | output | 1 | Shared serial clock, idle low |
| adc_mosi | output | 1 | Shared command line |
| adc_miso | input | N_ADC | One return data line per ADC |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | SAMPLE_W | Sample value |
| out_chan | output | MUX_W+IDX_W | Global channel tag {mux, adc} |
| out_last | output | 1 | Final word of a frame |
| overrun | output | 1 | Sticky missed-deadline flag |

## Verification
Each ADC model in the bench returns a value computed from its own index, the channel it was last commanded to and a per-frame epoch. An output that lags its channel by one transfer, reverses the ADC order or repeats an old frame therefore shows up as a wrong value, not only as a wrong tag. The main function is run with a full mask, with sparse masks, with only the lowest ADC and with only the highest ADC. Each is combined with a steady ready, an alternating ready and a bursty ready, so that the tests separate skipping logic from ordering logic and separate handshake holding from data capture. Directed runs then hold ready low past a deadline, change the mask in the middle of a frame and shorten the period, to show that overrun is set and stays set while the frame contents stay intact.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_GAP  = 2'd1,
    CTL_XFER = 2'd2
  } ctl_state_e;

  // index of the least significant set bit, 0 when none is set
  function automatic int lowest_set(input logic [31:0] m);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

  // remove the least significant set bit
  function automatic logic [31:0] clear_lowest(input logic [31:0] m);
    return m & (m - 32'd1);
  endfunction

  // true when at most one bit is set
  function automatic logic at_most_one(input logic [31:0] m);
    return (clear_lowest(m) == 32'd0);
  endfunction

endpackage

// File: rtl/mcs_frame_timer.sv
module mcs_frame_timer #(
  parameter int PERIOD_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);

  logic [PERIOD_W-1:0] cnt;
  logic                at_end;

  // a count at or past the limit wraps, so shortening the period takes effect at once
  assign at_end = (cnt >= (period - PERIOD_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= at_end;
      cnt  <= at_end ? '0 : cnt + PERIOD_W'(1);
    end
  end

endmodule

// File: rtl/mcs_spi_engine.sv
module mcs_spi_engine #(
  parameter int N_ADC     = 16,
  parameter int XFER_BITS = 16,
  parameter int HALF_DIV  = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [XFER_BITS-1:0]                cmd,
  input  logic [N_ADC-1:0]                    miso,
  output logic                                cs_n,
  output logic                                sclk,
  output logic                                mosi,
  output logic                                done,
  output logic [N_ADC-1:0][XFER_BITS-1:0]     rx
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(XFER_BITS);

  logic                 active;
  logic [DIV_W-1:0]     div;
  logic [BIT_W-1:0]     nbit;
  logic [XFER_BITS-1:0] tx_sr;
  logic                 half_end;
  logic                 rise_now;
  logic                 fall_now;
  logic                 last_bit;

  assign half_end = (div == DIV_W'(HALF_DIV - 1));
  assign rise_now = active && half_end && !sclk;
  assign fall_now = active && half_end && sclk;
  assign last_bit = (nbit == BIT_W'(XFER_BITS - 1));
  assign mosi     = !cs_n && tx_sr[XFER_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      div    <= '0;
      nbit   <= '0;
      tx_sr  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
          sclk   <= 1'b0;
          div    <= '0;
          nbit   <= '0;
          tx_sr  <= cmd;
        end
      end else begin
        div <= half_end ? '0 : div + DIV_W'(1);
        if (rise_now) sclk <= 1'b1;
        if (fall_now) begin
          sclk <= 1'b0;
          if (last_bit) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b1;
          end else begin
            nbit  <= nbit + BIT_W'(1);
            tx_sr <= {tx_sr[XFER_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  // one capture register per return line, all loaded on the same rising edge
  for (genvar k = 0; k < N_ADC; k++) begin : g_rx
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx[k] <= '0;
      end else if (rise_now) begin
        rx[k] <= {rx[k][XFER_BITS-2:0], miso[k]};
      end
    end
  end

endmodule

// File: rtl/mcs_out_stage.sv
module mcs_out_stage
  import mcs_pkg::*;
#(
  parameter int N_ADC    = 16,
  parameter int SAMPLE_W = 16,
  parameter int MUX_W    = 6,
  parameter int IDX_W    = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [N_ADC-1:0][SAMPLE_W-1:0]   load_data,
  input  logic [N_ADC-1:0]                 load_mask,
  input  logic [MUX_W-1:0]                 load_mux,
  input  logic                             load_last,
  input  logic                             out_ready,
  output logic                             out_valid,
  output logic [SAMPLE_W-1:0]              out_data,
  output logic [MUX_W+IDX_W-1:0]           out_chan,
  output logic                             out_last,
  output logic                             drained,
  output logic                             word_fire
);

  logic [N_ADC-1:0][SAMPLE_W-1:0] hold;
  logic [N_ADC-1:0]               pend;
  logic [MUX_W-1:0]               mux_q;
  logic                           last_q;
  logic [IDX_W-1:0]               cur;

  assign cur       = IDX_W'(lowest_set(32'(pend)));
  assign out_valid = |pend;
  assign out_data  = hold[cur];
  assign out_chan  = {mux_q, cur};
  assign out_last  = last_q && out_valid && at_most_one(32'(pend));
  assign drained   = ~|pend;
  assign word_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold   <= '0;
      pend   <= '0;
      mux_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      hold   <= load_data;
      pend   <= load_mask;
      mux_q  <= load_mux;
      last_q <= load_last;
    end else if (word_fire) begin
      pend <= N_ADC'(clear_lowest(32'(pend)));
    end
  end

endmodule

// File: rtl/mcs_adc_sequencer.sv
module mcs_adc_sequencer
  import mcs_pkg::*;
#(
  parameter int N_ADC      = 16,
  parameter int N_MUX      = 64,
  parameter int SAMPLE_W   = 16,
  parameter int HALF_DIV   = 2,
  parameter int PERIOD_W   = 20,
  parameter int GAP_W      = 8,
  parameter int CMD_CH_LSB = 8,
  localparam int MUX_W     = $clog2(N_MUX),
  localparam int IDX_W     = $clog2(N_ADC),
  localparam int CHAN_W    = MUX_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] frame_period,
  input  logic [GAP_W-1:0]    cs_gap,
  input  logic [N_ADC-1:0]    adc_enable,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                adc_mosi,
  input  logic [N_ADC-1:0]    adc_miso,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic [CHAN_W-1:0]   out_chan,
  output logic                out_last,
  output logic                overrun
);

  localparam int XFER_W  = $clog2(N_MUX + 2);
  localparam int N_XFER  = N_MUX + 1;

  // command word for transfer t: selects the channel converted next
  function automatic logic [SAMPLE_W-1:0] cmd_for(input logic [XFER_W-1:0] t);
    logic [SAMPLE_W-1:0] w;
    logic [MUX_W-1:0]    ch;
    ch = (t == XFER_W'(N_MUX)) ? '0 : MUX_W'(t);
    w  = '0;
    w[CMD_CH_LSB +: MUX_W] = ch;
    return w;
  endfunction

  ctl_state_e                     state;
  logic [XFER_W-1:0]              xfer_idx;
  logic [GAP_W-1:0]               gap_cnt;
  logic [N_ADC-1:0]               en_q;
  logic                           overrun_q;
  logic                           spi_start;
  logic [SAMPLE_W-1:0]            spi_cmd;

  // named internal events
  logic                           frame_tick;
  logic                           xfer_done;
  logic                           frame_busy;
  logic                           frame_start;
  logic                           frame_done;
  logic                           gap_ok;
  logic                           all_sent;
  logic                           launch;
  logic                           drained;
  logic                           word_fire;
  logic                           load;
  logic [MUX_W-1:0]               load_mux;
  logic                           load_last;
  logic [N_ADC-1:0][SAMPLE_W-1:0] rx_bank;

  assign frame_busy  = (state != CTL_IDLE);
  assign gap_ok      = (gap_cnt >= cs_gap);
  assign all_sent    = (xfer_idx == XFER_W'(N_XFER));
  assign frame_start = frame_tick && !frame_busy;
  assign frame_done  = (state == CTL_GAP) && all_sent && drained;
  assign launch      = (state == CTL_GAP) && !all_sent && drained && gap_ok;
  assign load        = (state == CTL_XFER) && xfer_done && (xfer_idx != '0);
  assign load_mux    = MUX_W'(xfer_idx - XFER_W'(1));
  assign load_last   = (xfer_idx == XFER_W'(N_MUX));
  assign overrun     = overrun_q;

  mcs_frame_timer #(
    .PERIOD_W (PERIOD_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (frame_period),
    .tick   (frame_tick)
  );

  mcs_spi_engine #(
    .N_ADC     (N_ADC),
    .XFER_BITS (SAMPLE_W),
    .HALF_DIV  (HALF_DIV)
  ) u_spi (
    .clk   (clk),
    .rst_n (rst_n),
    .start (spi_start),
    .cmd   (spi_cmd),
    .miso  (adc_miso),
    .cs_n  (adc_cs_n),
    .sclk  (adc_sclk),
    .mosi  (adc_mosi),
    .done  (xfer_done),
    .rx    (rx_bank)
  );

  mcs_out_stage #(
    .N_ADC    (N_ADC),
    .SAMPLE_W (SAMPLE_W),
    .MUX_W    (MUX_W),
    .IDX_W    (IDX_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (rx_bank),
    .load_mask (en_q),
    .load_mux  (load_mux),
    .load_last (load_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .out_last  (out_last),
    .drained   (drained),
    .word_fire (word_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= CTL_IDLE;
      xfer_idx  <= '0;
      gap_cnt   <= '0;
      en_q      <= '0;
      overrun_q <= 1'b0;
      spi_start <= 1'b0;
      spi_cmd   <= '0;
    end else begin
      spi_start <= 1'b0;
      if (state != CTL_XFER && gap_cnt != {GAP_W{1'b1}}) begin
        gap_cnt <= gap_cnt + GAP_W'(1);
      end
      if (frame_tick && frame_busy) begin
        overrun_q <= 1'b1;
      end
      unique case (state)
        CTL_IDLE: begin
          if (frame_start) begin
            en_q     <= adc_enable;
            xfer_idx <= '0;
            state    <= CTL_GAP;
          end
        end
        CTL_GAP: begin
          if (frame_done) begin
            state <= CTL_IDLE;
          end else if (launch) begin
            spi_start <= 1'b1;
            spi_cmd   <= cmd_for(xfer_idx);
            state     <= CTL_XFER;
          end
        end
        CTL_XFER: begin
          if (xfer_done) begin
            gap_cnt  <= '0;
            xfer_idx <= xfer_idx + XFER_W'(1);
            state    <= CTL_GAP;
          end
        end
        default: state <= CTL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mcs_adc_sequencer_chk.sv
module mcs_adc_sequencer_chk #(
  parameter int N_ADC    = 16,
  parameter int N_MUX    = 64,
  parameter int SAMPLE_W = 16,
  parameter int GAP_W    = 8,
  localparam int MUX_W   = $clog2(N_MUX),
  localparam int IDX_W   = $clog2(N_ADC),
  localparam int CHAN_W  = MUX_W + IDX_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                adc_cs_n,
  input logic                adc_sclk,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_data,
  input logic [CHAN_W-1:0]   out_chan,
  input logic                out_last,
  input logic                overrun,
  input logic                frame_tick,
  input logic                frame_busy,
  input logic [N_ADC-1:0]    en_q,
  input logic [GAP_W-1:0]    cs_gap
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (adc_cs_n) begin
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end else begin
      hi_cnt <= '0;
    end
  end

  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                    $stable(out_chan) && $stable(out_last)));

  a_r9_no_launch_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !out_valid);

  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_cnt >= 16'(cs_gap)));

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r11_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && frame_busy) |=> overrun);

  a_r6_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> en_q[out_chan[IDX_W-1:0]]);

  a_r7_last_channel: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && (out_chan[CHAN_W-1 -: MUX_W] == MUX_W'(N_MUX - 1))));

endmodule

bind mcs_adc_sequencer mcs_adc_sequencer_chk #(
  .N_ADC    (N_ADC),
  .N_MUX    (N_MUX),
  .SAMPLE_W (SAMPLE_W),
  .GAP_W    (GAP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adc_cs_n   (adc_cs_n),
  .adc_sclk   (adc_sclk),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_chan   (out_chan),
  .out_last   (out_last),
  .overrun    (overrun),
  .frame_tick (frame_tick),
  .frame_busy (frame_busy),
  .en_q       (en_q),
  .cs_gap     (cs_gap)
);

// File: tb/mcs_adc_sequencer_tb.sv
module mcs_adc_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NA         = 16;
  localparam int NM         = 64;
  localparam int FRAME_PER  = 8000;
  localparam int WD_LIMIT   = 190000;
  localparam int NVEC       = 5;
  // {enable mask, cs gap, ready mode}
  localparam logic [27:0] VEC [NVEC] = '{
    {16'hFFFF, 8'd4,  4'd0},
    {16'h8421, 8'd12, 4'd1},
    {16'h0001, 8'd1,  4'd2},
    {16'h8000, 8'd20, 4'd2},
    {16'h5AA5, 8'd0,  4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] frame_period = 20'(FRAME_PER);
  logic [7:0]  cs_gap = 8'd4;
  logic [15:0] adc_enable = 16'hFFFF;
  logic        adc_cs_n, adc_sclk, adc_mosi;
  logic [15:0] adc_miso;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic [9:0]  out_chan;
  logic        out_last;
  logic        overrun;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  mcs_adc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .frame_period(frame_period), .cs_gap(cs_gap),
    .adc_enable(adc_enable), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_mosi(adc_mosi), .adc_miso(adc_miso), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_chan(out_chan),
    .out_last(out_last), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ADC models
  function automatic logic [15:0] mk(input int k, input int ch, input int ep);
    return 16'((k * 4099 + ch * 97 + ep * 31) ^ 16'hA5C3);
  endfunction

  int          epoch = 0;
  logic [5:0]  sel [NA];
  logic [15:0] sh [NA];
  logic [15:0] cmd_sr = '0;
  logic [15:0] cmd_log [128];
  int          cmd_n = 0;
  int          sclk_cnt = 0;
  int          bad_sclk = 0;
  int          hi_cnt = 0;
  int          min_hi = 1000000;
  int          start_stamp = -1;

  initial for (int k = 0; k < NA; k++) begin sel[k] = 6'd63; sh[k] = '0; end

  always_comb for (int k = 0; k < NA; k++) adc_miso[k] = sh[k][15];

  always @(negedge adc_cs_n) begin
    if (rst_n) begin
      for (int k = 0; k < NA; k++) sh[k] = mk(k, int'(sel[k]), epoch);
      sclk_cnt = 0;
      if (cmd_n == 0) start_stamp = cyc;
    end
  end

  always @(negedge adc_sclk) begin
    if (rst_n && !adc_cs_n) for (int k = 0; k < NA; k++) sh[k] = {sh[k][14:0], 1'b0};
  end

  always @(posedge adc_sclk) begin
    if (rst_n && !adc_cs_n) begin
      cmd_sr = {cmd_sr[14:0], adc_mosi};
      sclk_cnt++;
    end
  end

  always @(posedge adc_cs_n) begin
    if (rst_n) begin
      for (int k = 0; k < NA; k++) sel[k] = cmd_sr[13:8];
      if (cmd_n < 128) cmd_log[cmd_n] = cmd_sr;
      cmd_n++;
      if (sclk_cnt != 16) bad_sclk++;
    end
  end

  // cycle counter, CS high-time monitor and watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (adc_cs_n) hi_cnt++;
      else begin
        if (hi_cnt > 0 && hi_cnt < min_hi) min_hi = hi_cnt;
        hi_cnt = 0;
      end
    end
    if (cyc > WD_LIMIT) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog expired: cycles=%0d limit=%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic [15:0] rx_data [1024];
  logic [9:0]  rx_chan [1024];
  logic        rx_last [1024];
  int          n_rx;

  // mode 0 always ready, 1 alternating, 2 bursty, 3 low for a long stall
  task automatic run_frame(input int mode, input bit swap, input logic [15:0] alt_mask);
    bit got_last = 0;
    bit swapped = 0;
    n_rx = 0;
    for (int c = 0; c < 40000 && !got_last; c++) begin
      @(negedge clk);
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (c % 2 == 1);
        2:       out_ready = ((c % 7) < 4);
        default: out_ready = (c >= 15000);
      endcase
      if (swap && !swapped && n_rx == 5) begin
        adc_enable = alt_mask;
        swapped = 1;
      end
      if (out_valid && out_ready) begin
        if (n_rx < 1024) begin
          rx_data[n_rx] = out_data;
          rx_chan[n_rx] = out_chan;
          rx_last[n_rx] = out_last;
        end
        if (out_last) got_last = 1;
        n_rx++;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic check_frame(input logic [15:0] mask, input int ep);
    int idx = 0;
    int bad = 0;
    int bad_last = 0;
    int pc = $countones(mask);
    check_eq("R6", "words per frame", n_rx, NM * pc);
    for (int ch = 0; ch < NM; ch++) begin
      for (int k = 0; k < NA; k++) begin
        if (mask[k] && idx < n_rx && idx < 1024) begin
          if (rx_data[idx] !== mk(k, ch, ep) || rx_chan[idx] !== {6'(ch), 4'(k)}) begin
            if (bad == 0)
              $display("FAIL R4 R5 word %0d: actual data=%h chan=%0d expected data=%h chan=%0d",
                       idx, rx_data[idx], rx_chan[idx], mk(k, ch, ep), {6'(ch), 4'(k)});
            bad++;
          end
          if (rx_last[idx] !== (idx == NM * pc - 1)) bad_last++;
          idx++;
        end
      end
    end
    checks++;
    if (bad != 0) failures++;
    check_eq("R7", "misplaced last flags", bad_last, 0);
  endtask

  task automatic check_cmds();
    int bad = 0;
    check_eq("R1", "transfers per frame", cmd_n, NM + 1);
    for (int t = 0; t <= NM && t < cmd_n; t++) begin
      if (cmd_log[t] !== {2'b00, 6'((t == NM) ? 0 : t), 8'h00}) begin
        if (bad == 0)
          $display("FAIL R3 command %0d: actual=%h expected=%h", t, cmd_log[t],
                   {2'b00, 6'((t == NM) ? 0 : t), 8'h00});
        bad++;
      end
    end
    checks++;
    if (bad != 0) failures++;
    check_eq("R2", "transfers without 16 clocks", bad_sclk, 0);
  endtask

  task automatic clear_mon();
    cmd_n = 0;
    bad_sclk = 0;
    min_hi = 1000000;
  endtask

  initial begin
    int prev_start;
    logic [15:0] m;
    // R12 reset state
    repeat (4) @(negedge clk);
    check_eq("R12", "cs_n in reset", adc_cs_n, 1);
    check_eq("R12", "sclk in reset", adc_sclk, 0);
    check_eq("R12", "mosi in reset", adc_mosi, 0);
    check_eq("R12", "out_valid in reset", out_valid, 0);
    check_eq("R12", "overrun in reset", overrun, 0);

    prev_start = -1;
    for (int v = 0; v < NVEC; v++) begin
      m = VEC[v][27:12];
      adc_enable = m;
      cs_gap = VEC[v][11:4];
      epoch = v + 1;
      if (v == 0) begin
        @(negedge clk);
        rst_n = 1'b1;
        start_stamp = -1;
      end
      run_frame(int'(VEC[v][3:0]), 1'b0, 16'h0);
      check_frame(m, v + 1);
      check_cmds();
      checks++;
      if (min_hi < int'(VEC[v][11:4])) begin
        failures++;
        $display("FAIL R10 cs high time: actual=%0d expected>=%0d", min_hi, VEC[v][11:4]);
      end
      if (v == 0) begin
        checks++;
        if (start_stamp < FRAME_PER || start_stamp > FRAME_PER + 12) begin
          failures++;
          $display("FAIL R1 first frame start cycle: actual=%0d expected=%0d..%0d",
                   start_stamp, FRAME_PER, FRAME_PER + 12);
        end
      end else begin
        check_eq("R1", "frame start spacing", start_stamp - prev_start, FRAME_PER);
      end
      prev_start = start_stamp;
      clear_mon();
    end
    check_eq("R11", "overrun after on-time frames", overrun, 0);

    // R6 mask change in mid-frame is ignored by that frame
    cs_gap = 8'd3;
    adc_enable = 16'hF0F0;
    epoch = 20;
    run_frame(0, 1'b1, 16'h0003);
    check_frame(16'hF0F0, 20);
    check_cmds();
    clear_mon();
    check_eq("R11", "overrun after mask swap frame", overrun, 0);

    // R8 R11 long stall pushes the frame past its deadline
    adc_enable = 16'hFFFF;
    epoch = 21;
    run_frame(3, 1'b0, 16'h0);
    check_frame(16'hFFFF, 21);
    check_cmds();
    clear_mon();
    check_eq("R11", "overrun after stalled frame", overrun, 1);

    // R11 flag stays set through a following on-time frame
    epoch = 22;
    run_frame(0, 1'b0, 16'h0);
    check_frame(16'hFFFF, 22);
    clear_mon();
    check_eq("R11", "overrun sticky", overrun, 1);

    // R12 reset clears the flag
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R12", "overrun cleared by reset", overrun, 0);
    check_eq("R12", "out_valid cleared by reset", out_valid, 0);
    check_eq("R12", "cs_n high in reset", adc_cs_n, 1);

    // R11 period shorter than a frame: ticks are dropped, frame stays whole
    frame_period = 20'd2500;
    cs_gap = 8'd2;
    epoch = 30;
    clear_mon();
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(0, 1'b0, 16'h0);
    check_frame(16'hFFFF, 30);
    check_cmds();
    check_eq("R11", "overrun with short period", overrun, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule